// File: doc/BRIEF.md
# Fetch and Data Access Conflict Arbiter

This block sits between a CPU's two memory request streams, the instruction fetch port and the data load/store port, and the memories behind them. Each cycle it decodes the address on each port into a memory region: the flash region, the internal RAM, the display RAM, or none of these. It then decides whether the two accesses can run at the same time. When they would compete for the same memory path, the data access goes first. The fetch is held back, and a fetch-stall output is raised, until the data access reports completion.

Grants are levels. A port's grant rises in the cycle its request is accepted and stays high through the cycle in which that port's `done` input is seen. Wait states come from the memory side through the two `done` inputs, so the stall on the fetch side lasts exactly as many cycles as the data access does. A fetch that already holds its grant is never interrupted by a data request that arrives later. A fetch that had to wait is served ahead of any new data request.

Top module: `fetch_data_arbiter`

## Requirements
- R1: The flash region covers byte addresses 0x8000 up to and including 0x87FFF. An address one below or one above that range is not in the flash region.
- R2: A fetch from the flash region and a data access to the flash region are never granted in the same cycle.
- R3: A fetch from the flash region and a data access to the display RAM region are never granted in the same cycle.
- R4: A fetch from the internal RAM region and a data access to the internal RAM region are never granted in the same cycle.
- R5: Any other pair of regions does not conflict. In that case both grants are high in the same cycle as the requests, including the fetch-from-display-RAM and no-region cases.
- R6: When both requests arrive together and conflict, `data_gnt` is high at once and `fetch_gnt` is low. `fetch_stall` is high in every cycle in which a fetch is requested but not granted, and only while data holds its grant.
- R7: A stalled fetch is granted in the cycle after the data port's `data_done` is seen, so it stalls for exactly the number of cycles the data access takes (one cycle for a single-cycle data access).
- R8: A granted fetch keeps its grant until `fetch_done`. A conflicting data request that arrives later gets no grant until the cycle after `fetch_done`.
- R9: A fetch that was stalled by a conflict is granted ahead of a new conflicting data request issued right after the previous data access finished.
- R10: After reset, with no requests, both grants and the stall are low. A granted data access keeps its grant until `data_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_req | input | 1 | Instruction fetch request, held until done |
| fetch_addr | input | ADDR_W | Fetch byte address, stable while requested |
| fetch_done | input | 1 | Fetch completes this cycle (only while granted) |
| data_req | input | 1 | Data access request, held until done |
| data_addr | input | ADDR_W | Data byte address, stable while requested |
| data_done | input | 1 | Data access completes this cycle (only while granted) |
| fetch_gnt | output | 1 | Fetch may use its memory path this cycle |
| data_gnt | output | 1 | Data access may use its memory path this cycle |
| fetch_stall | output | 1 | Fetch requested but held back by a conflict |

## Verification
The assertions assume the usual request discipline on each port. A request and its address stay unchanged from the first requesting cycle until the cycle its `done` is seen, and `done` is only raised while that port's grant is high. The bench drives every scenario through a single task that applies these inputs together for one cycle. Each scenario holds its requests and addresses steady, raises `done` only in cycles where the grant was computed to be high, and drops the request in the cycle after that. In this way the stimulus never leaves the contract the properties rely on.

// File: rtl/fda_pkg.sv
package fda_pkg;

   typedef enum logic [1:0] {
      RGN_OTHER = 2'd0,
      RGN_FLASH = 2'd1,
      RGN_IRAM  = 2'd2,
      RGN_DISP  = 2'd3
   } region_e;

   localparam int unsigned NUM_PORTS = 2;
   localparam int unsigned PORT_FETCH = 0;
   localparam int unsigned PORT_DATA  = 1;

   function automatic logic spans_overlap(input longint unsigned a_lo,
                                          input longint unsigned a_hi,
                                          input longint unsigned b_lo,
                                          input longint unsigned b_hi);
      return !((a_hi < b_lo) || (b_hi < a_lo));
   endfunction

endpackage

// File: rtl/fda_region_decode.sv
module fda_region_decode #(
   parameter int unsigned ADDR_W     = 24,
   parameter int unsigned FLASH_LO   = 32'h0000_8000,
   parameter int unsigned FLASH_HI   = 32'h0008_7FFF,
   parameter int unsigned IRAM_LO    = 32'h0000_0000,
   parameter int unsigned IRAM_HI    = 32'h0000_3FFF,
   parameter int unsigned DISP_LO    = 32'h0009_0000,
   parameter int unsigned DISP_HI    = 32'h0009_07FF
) (
   input  logic [ADDR_W-1:0] addr_i,
   output fda_pkg::region_e  region_o
);
   import fda_pkg::*;

   localparam int unsigned PAD_W = 32 - ADDR_W;

   logic [31:0] addr_ext;
   logic        in_flash, in_iram, in_disp;

   generate
      if (PAD_W == 0) begin : g_full
         assign addr_ext = addr_i;
      end else begin : g_pad
         assign addr_ext = {{PAD_W{1'b0}}, addr_i};
      end
   endgenerate

   assign in_flash = (addr_ext >= FLASH_LO) && (addr_ext <= FLASH_HI);
   assign in_iram  = (addr_ext >= IRAM_LO)  && (addr_ext <= IRAM_HI);
   assign in_disp  = (addr_ext >= DISP_LO)  && (addr_ext <= DISP_HI);

   always_comb begin
      region_o = RGN_OTHER;
      if (in_flash)     region_o = RGN_FLASH;
      else if (in_iram) region_o = RGN_IRAM;
      else if (in_disp) region_o = RGN_DISP;
   end

   always_comb begin
      a_r1_one_region: assert ($countones({in_flash, in_iram, in_disp}) <= 1)
         else $error("address %h decodes into more than one region", addr_ext);
   end

endmodule

// File: rtl/fda_clash_rule.sv
module fda_clash_rule (
   input  fda_pkg::region_e fetch_rgn_i,
   input  fda_pkg::region_e data_rgn_i,
   output logic             clash_o
);
   import fda_pkg::*;

   logic flash_path_clash;
   logic iram_path_clash;

   // R2 R3: flash fetch shares its path with flash and display RAM data
   assign flash_path_clash = (fetch_rgn_i == RGN_FLASH) &&
                             ((data_rgn_i == RGN_FLASH) || (data_rgn_i == RGN_DISP));
   // R4: internal RAM fetch shares its path with internal RAM data
   assign iram_path_clash  = (fetch_rgn_i == RGN_IRAM) && (data_rgn_i == RGN_IRAM);

   assign clash_o = flash_path_clash || iram_path_clash;

endmodule

// File: rtl/fda_grant_core.sv
module fda_grant_core (
   input  logic clk,
   input  logic rst_n,
   input  logic fetch_req_i,
   input  logic fetch_done_i,
   input  logic data_req_i,
   input  logic data_done_i,
   input  logic clash_i,
   output logic fetch_gnt_o,
   output logic data_gnt_o,
   output logic fetch_stall_o
);

   logic fetch_busy_q, data_busy_q, fetch_owed_q;
   logic contend;
   logic fetch_ok, data_ok;

   assign contend = fetch_req_i && data_req_i && clash_i;

   // fetch proceeds if already running, if no contention, or if it is owed
   // a turn and the data port has released its path
   assign fetch_ok = fetch_busy_q || !contend || (fetch_owed_q && !data_busy_q);
   // data proceeds if already running, if no contention, or if the fetch
   // neither runs nor is owed a turn
   assign data_ok  = data_busy_q || !contend || (!fetch_busy_q && !fetch_owed_q);

   assign fetch_gnt_o   = fetch_req_i && fetch_ok;
   assign data_gnt_o    = data_req_i  && data_ok;
   assign fetch_stall_o = fetch_req_i && !fetch_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fetch_busy_q <= 1'b0;
         data_busy_q  <= 1'b0;
         fetch_owed_q <= 1'b0;
      end else begin
         fetch_busy_q <= fetch_gnt_o && !fetch_done_i;
         data_busy_q  <= data_gnt_o  && !data_done_i;
         fetch_owed_q <= fetch_stall_o;
      end
   end

   a_r2_never_both_on_clash: assert property (@(posedge clk) disable iff (!rst_n)
      !(fetch_gnt_o && data_gnt_o && clash_i));

   a_r5_parallel_when_free: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req_i && data_req_i && !clash_i) |-> (fetch_gnt_o && data_gnt_o));

   a_r6_stall_behind_data: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_stall_o |-> data_gnt_o);

   a_r7_fetch_after_data_done: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_stall_o && data_done_i) |=> (!fetch_req_i || fetch_gnt_o));

   a_r8_fetch_not_preempted: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_gnt_o && !fetch_done_i) |=> (!fetch_req_i || fetch_gnt_o));

   a_r10_data_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
      (data_gnt_o && !data_done_i) |=> (!data_req_i || data_gnt_o));

endmodule

// File: rtl/fetch_data_arbiter.sv
module fetch_data_arbiter #(
   parameter int unsigned ADDR_W   = 24,
   parameter int unsigned FLASH_LO = 32'h0000_8000,
   parameter int unsigned FLASH_HI = 32'h0008_7FFF,
   parameter int unsigned IRAM_LO  = 32'h0000_0000,
   parameter int unsigned IRAM_HI  = 32'h0000_3FFF,
   parameter int unsigned DISP_LO  = 32'h0009_0000,
   parameter int unsigned DISP_HI  = 32'h0009_07FF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_req,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              fetch_done,
   input  logic              data_req,
   input  logic [ADDR_W-1:0] data_addr,
   input  logic              data_done,
   output logic              fetch_gnt,
   output logic              data_gnt,
   output logic              fetch_stall
);
   import fda_pkg::*;

   localparam logic BAD_WIDTH = (ADDR_W < 1) || (ADDR_W > 32);
   localparam logic BAD_ORDER = (FLASH_LO > FLASH_HI) || (IRAM_LO > IRAM_HI) ||
                                (DISP_LO > DISP_HI);
   localparam logic OVERLAP   = spans_overlap(FLASH_LO, FLASH_HI, IRAM_LO, IRAM_HI) ||
                                spans_overlap(FLASH_LO, FLASH_HI, DISP_LO, DISP_HI) ||
                                spans_overlap(IRAM_LO,  IRAM_HI,  DISP_LO, DISP_HI);

   generate
      if (BAD_WIDTH) begin : g_bad_width
         $error("ADDR_W must lie between 1 and 32");
      end
      if (BAD_ORDER) begin : g_bad_order
         $error("a region has its low bound above its high bound");
      end
      if (OVERLAP) begin : g_overlap
         $error("memory regions must not overlap");
      end
   endgenerate

   logic [ADDR_W-1:0] port_addr [NUM_PORTS];
   region_e           port_rgn  [NUM_PORTS];
   logic              clash;

   assign port_addr[PORT_FETCH] = fetch_addr;
   assign port_addr[PORT_DATA]  = data_addr;

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
         fda_region_decode #(
            .ADDR_W   (ADDR_W),
            .FLASH_LO (FLASH_LO),
            .FLASH_HI (FLASH_HI),
            .IRAM_LO  (IRAM_LO),
            .IRAM_HI  (IRAM_HI),
            .DISP_LO  (DISP_LO),
            .DISP_HI  (DISP_HI)
         ) u_dec (
            .addr_i   (port_addr[p]),
            .region_o (port_rgn[p])
         );
      end
   endgenerate

   fda_clash_rule u_rule (
      .fetch_rgn_i (port_rgn[PORT_FETCH]),
      .data_rgn_i  (port_rgn[PORT_DATA]),
      .clash_o     (clash)
   );

   fda_grant_core u_core (
      .clk           (clk),
      .rst_n         (rst_n),
      .fetch_req_i   (fetch_req),
      .fetch_done_i  (fetch_done),
      .data_req_i    (data_req),
      .data_done_i   (data_done),
      .clash_i       (clash),
      .fetch_gnt_o   (fetch_gnt),
      .data_gnt_o    (data_gnt),
      .fetch_stall_o (fetch_stall)
   );

   a_r4_iram_pair_serial: assert property (@(posedge clk) disable iff (!rst_n)
      !(fetch_gnt && data_gnt &&
        (port_rgn[PORT_FETCH] == RGN_IRAM) && (port_rgn[PORT_DATA] == RGN_IRAM)));

   a_r3_flash_disp_serial: assert property (@(posedge clk) disable iff (!rst_n)
      !(fetch_gnt && data_gnt &&
        (port_rgn[PORT_FETCH] == RGN_FLASH) && (port_rgn[PORT_DATA] == RGN_DISP)));

   a_r6_no_grant_without_req: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetch_req |-> !fetch_gnt && !fetch_stall) and (!data_req |-> !data_gnt));

endmodule

// File: tb/tb_fetch_data_arbiter.sv
module tb_fetch_data_arbiter;

   localparam int AW = 24;
   localparam logic [AW-1:0] A_FLASH    = 24'h01_0000;
   localparam logic [AW-1:0] A_FLASH_LO = 24'h00_8000;
   localparam logic [AW-1:0] A_FLASH_HI = 24'h08_7FFF;
   localparam logic [AW-1:0] A_BELOW    = 24'h00_7FFF;
   localparam logic [AW-1:0] A_ABOVE    = 24'h08_8000;
   localparam logic [AW-1:0] A_IRAM     = 24'h00_1000;
   localparam logic [AW-1:0] A_DISP     = 24'h09_0100;
   localparam logic [AW-1:0] A_OTHER    = 24'h0C_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fetch_req = 1'b0, fetch_done = 1'b0, data_req = 1'b0, data_done = 1'b0;
   logic [AW-1:0] fetch_addr = '0, data_addr = '0;
   logic fetch_gnt, data_gnt, fetch_stall;

   int checks = 0;
   int failures = 0;
   bit reported = 1'b0;

   always #2 clk = ~clk;

   fetch_data_arbiter dut (
      .clk(clk), .rst_n(rst_n),
      .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_done(fetch_done),
      .data_req(data_req), .data_addr(data_addr), .data_done(data_done),
      .fetch_gnt(fetch_gnt), .data_gnt(data_gnt), .fetch_stall(fetch_stall)
   );

   task automatic summary();
      if (!reported) begin
         reported = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   // apply one cycle of inputs (called just after a falling edge), check the
   // combinational outputs mid-cycle, then move to the next falling edge
   task automatic cyc(input logic ir, input logic [AW-1:0] ia, input logic idn,
                      input logic dr, input logic [AW-1:0] da, input logic ddn,
                      input logic e_fg, input logic e_dg, input logic e_st,
                      input string tag);
      fetch_req = ir; fetch_addr = ia; fetch_done = idn;
      data_req = dr;  data_addr = da;  data_done = ddn;
      #1;
      checks++;
      if ({fetch_gnt, data_gnt, fetch_stall} !== {e_fg, e_dg, e_st}) begin
         failures++;
         $display("FAIL %s: {fetch_gnt,data_gnt,fetch_stall} actual=%b%b%b expected=%b%b%b",
                  tag, fetch_gnt, data_gnt, fetch_stall, e_fg, e_dg, e_st);
      end
      @(negedge clk);
   endtask

   task automatic idle();
      cyc(0, '0, 0, 0, '0, 0, 0, 0, 0, "R10 idle between scenarios");
   endtask

   task automatic t_reset();
      cyc(0, '0, 0, 0, '0, 0, 0, 0, 0, "R10 reset state");
   endtask

   // both granted in the request cycle, both finish there
   task automatic t_parallel(input logic [AW-1:0] fa, input logic [AW-1:0] da, input string tag);
      cyc(1, fa, 1, 1, da, 1, 1, 1, 0, tag);
      idle();
   endtask

   // data first for nd cycles with fetch stalled, fetch the cycle after data_done
   task automatic t_conflict(input logic [AW-1:0] fa, input logic [AW-1:0] da,
                             input int nd, input string tag);
      for (int k = 0; k < nd; k++)
         cyc(1, fa, 0, 1, da, (k == nd - 1), 0, 1, 1, {tag, " R6 data first, fetch stalled"});
      cyc(1, fa, 1, 0, da, 0, 1, 0, 0, {tag, " R7 fetch granted after data_done"});
      idle();
   endtask

   task automatic t_no_preempt();
      cyc(1, A_FLASH, 0, 0, '0, 0, 1, 0, 0, "R8 fetch granted alone");
      cyc(1, A_FLASH, 0, 1, A_FLASH, 0, 1, 0, 0, "R8 late data waits");
      cyc(1, A_FLASH, 1, 1, A_FLASH, 0, 1, 0, 0, "R8 data still waits at fetch_done");
      cyc(0, '0, 0, 1, A_FLASH, 1, 0, 1, 0, "R8 data granted after fetch_done");
      idle();
   endtask

   task automatic t_owed();
      cyc(1, A_FLASH, 0, 1, A_DISP, 1, 0, 1, 1, "R9 first data wins");
      cyc(1, A_FLASH, 1, 1, A_FLASH, 0, 1, 0, 0, "R9 waiting fetch beats new data");
      cyc(0, '0, 0, 1, A_FLASH, 1, 0, 1, 0, "R9 new data served after fetch");
      idle();
   endtask

   task automatic t_held_data();
      cyc(0, '0, 0, 1, A_IRAM, 0, 0, 1, 0, "R10 data granted");
      cyc(0, '0, 0, 1, A_IRAM, 0, 0, 1, 0, "R10 data grant held");
      cyc(0, '0, 0, 1, A_IRAM, 1, 0, 1, 0, "R10 data grant held to done");
      idle();
   endtask

   initial begin
      #(4 * 200000);
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finished");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();

      t_conflict(A_FLASH, A_FLASH, 3, "R2 flash/flash");
      t_conflict(A_FLASH, A_DISP, 2, "R3 flash/disp");
      t_conflict(A_IRAM, A_IRAM, 1, "R4 iram/iram single-cycle");

      t_parallel(A_FLASH, A_IRAM, "R5 flash fetch, iram data");
      t_parallel(A_IRAM, A_FLASH, "R5 iram fetch, flash data");
      t_parallel(A_IRAM, A_DISP, "R5 iram fetch, disp data");
      t_parallel(A_DISP, A_DISP, "R5 disp fetch, disp data");
      t_parallel(A_OTHER, A_FLASH, "R5 other fetch, flash data");

      t_conflict(A_FLASH_LO, A_FLASH, 1, "R1 low flash bound");
      t_conflict(A_FLASH_HI, A_FLASH, 1, "R1 high flash bound");
      t_parallel(A_BELOW, A_FLASH, "R1 one below flash");
      t_parallel(A_ABOVE, A_FLASH, "R1 one above flash");

      t_no_preempt();
      t_owed();
      t_held_data();

      summary();
   end

endmodule